// File: doc/BRIEF.md
# Ternary-Table Programmable Header Parser

This block pulls protocol headers out of the front of a packet. It does not hardwire any protocol. A small ternary match table, written through a configuration port, holds the parse graph. The packet arrives as 8-byte beats. The block stores the first `BUF_BYTES` bytes in a local capture buffer and ignores the rest of the packet, although it still accepts those beats. It then walks the graph one transition per clock. Each lookup uses the current state ID and a 16-bit lookahead key. The winning entry gives four things: the next state, the length of that state's header, where to fetch the following key, and whether to copy the header into the output header vector.

The phases of the controller are named here. IDLE waits for a start-of-packet beat and is the only phase that accepts table writes. FILL collects the remaining beats until end-of-packet. WALK does one table lookup per cycle. DONE raises a one-cycle completion pulse. The transitions are:
- IDLE→FILL on a start-of-packet beat that is not also the last beat.
- IDLE→WALK on a start-of-packet beat that is also the last beat.
- FILL→WALK on the end-of-packet beat.
- WALK→DONE when no entry matches, a header runs past the captured bytes, or the hop limit is reached.
- DONE→IDLE unconditionally.

A new protocol is added by writing more table entries. For example, a custom header can be placed between IPv4 and TCP this way.

Top module: `hdr_parser`

## Requirements
- R1: After reset, every table entry is invalid and `in_ready` is 1. `parse_done`, `parse_err`, `hdr_found` and `hdr_vec` are all 0. A packet parsed against the empty table finishes with no headers found and no error.
- R2: Beat byte ordering:
  - Byte 0 of a beat is `in_data[63:56]`.
  - On the end-of-packet beat, `in_nbytes` (1..8) gives the number of valid bytes.
  - Bytes beyond `BUF_BYTES` are dropped.
  - `in_ready` is 0 from the cycle after the end-of-packet beat until the block is back in IDLE.
- R3: An entry hits when it is valid and matches the lookup pair under its masks. The lookup pair is {state, key}. A mask bit of 1 means that bit is compared; a mask bit of 0 means it is ignored. When several entries hit, the one with the lowest index wins.
- R4: The walk starts in state 0 with key 0. On a hit, the parser does four things:
  - It enters the next state and sets `hdr_found[next]`.
  - It moves its byte cursor forward by the header length.
  - It reads the next key at cursor+key offset, where the cursor is the new header's start.
  - It builds the key according to the key-width field: 2 gives a big-endian 16-bit value, 1 gives one byte zero-extended, and 0 gives the key 0.
- R5: When the extract bit is 1, the header's bytes are copied into `hdr_vec` at their packet byte offsets; packet byte i goes to `hdr_vec[8*i+:8]`. When the extract bit is 0, those bytes of `hdr_vec` stay 0, but the header's found bit is still set.
- R6: When no entry hits, the parse ends with `parse_err`=0. Everything found so far is kept.
- R7: A header that ends beyond the captured length ends the parse with `parse_err`=1. That header's found bit and its bytes stay clear. A header that ends exactly at the captured length is accepted.
- R8: A hit that occurs after `MAX_HOPS` transitions have already been taken ends the parse with `parse_err`=1.
- R9: Table writes are applied only in IDLE. A write issued in any other phase has no effect.
- R10: `parse_done` is high for exactly one cycle. `hdr_vec`, `hdr_found` and `parse_err` hold their values until the next start-of-packet beat.
- R11: Writing extra entries changes the parse graph with no other change to the block. For example, IPv4 protocol 0xFE can be routed to an 8-byte custom header whose byte 0 selects TCP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_data | input | 64 | Beat bytes, byte 0 in the top lane |
| in_nbytes | input | 4 | Valid bytes in the last beat |
| in_ready | output | 1 | Beat accepted |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 5 | Entry index |
| cfg_vld | input | 1 | Entry valid |
| cfg_state | input | 6 | Match state value |
| cfg_state_mask | input | 6 | State care mask |
| cfg_key | input | 16 | Match key value |
| cfg_key_mask | input | 16 | Key care mask |
| cfg_next | input | 6 | Next state ID |
| cfg_len | input | 8 | Next header length in bytes |
| cfg_koff | input | 8 | Next key offset in that header |
| cfg_kw | input | 2 | Next key width code (0, 1 or 2 bytes) |
| cfg_extract | input | 1 | Copy next header to the vector |
| hdr_vec | output | 1024 | Extracted header bytes |
| hdr_found | output | 64 | One bit per state reached |
| parse_done | output | 1 | One-cycle completion pulse |
| parse_err | output | 1 | Parse ended in error |

## Verification
A sweep crosses five EtherType values with four L4 protocol values, once on the base graph and once after the custom-header entries are added. The sweep tells apart the IPv4/IPv6 branches, the TCP/UDP leaves, the extract-on and extract-off cases, and the outcome when the graph has no edge for a value. Two EtherTypes both match a wide masked entry, but only one also matches a lower-index exact entry, so the pair separates priority from don't-care matching. Length patterns land exactly on a header's end, one byte short of it, and far beyond the capture buffer, which separates accepted parses from truncation errors. A self-looping graph exercises the hop limit. A table write issued in the middle of a packet is followed by a packet that depends on the entry the write targeted.

// File: rtl/hdrp_pkg.sv
package hdrp_pkg;
    localparam int STATE_W = 6;
    localparam int KEY_W   = 16;
    localparam int LEN_W   = 8;

    typedef struct packed {
        logic               vld;
        logic [STATE_W-1:0] st;
        logic [STATE_W-1:0] st_m;
        logic [KEY_W-1:0]   key;
        logic [KEY_W-1:0]   key_m;
        logic [STATE_W-1:0] nxt;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   koff;
        logic [1:0]         kw;
        logic               ext;
    } rule_t;

    typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_WALK, PH_DONE} phase_t;
endpackage

// File: rtl/hdrp_tcam.sv
module hdrp_tcam
    import hdrp_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  rule_t              wr_rule,
    input  logic [STATE_W-1:0] look_st,
    input  logic [KEY_W-1:0]   look_key,
    output logic               hit,
    output rule_t              hit_rule
);
    rule_t             tbl [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]  sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_rule;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl[g].vld
                       && (((tbl[g].st  ^ look_st)  & tbl[g].st_m)  == '0)
                       && (((tbl[g].key ^ look_key) & tbl[g].key_m) == '0);
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel = IDX_W'(i);
                hit = 1'b1;
            end
        end
        hit_rule = tbl[sel];
    end

    p_hit_agrees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_rule.vld
                 && (((hit_rule.st ^ look_st) & hit_rule.st_m) == '0)
                 && (((hit_rule.key ^ look_key) & hit_rule.key_m) == '0)));
endmodule

// File: rtl/hdrp_capture.sv
module hdrp_capture #(
    parameter int BUF_BYTES  = 128,
    parameter int BEAT_BYTES = 8,
    localparam int CNT_W     = $clog2(BUF_BYTES + BEAT_BYTES + 1),
    localparam int NB_W      = $clog2(BEAT_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat_en,
    input  logic                    beat_first,
    input  logic [BEAT_BYTES*8-1:0] beat_data,
    input  logic [NB_W-1:0]         beat_nbytes,
    output logic [BUF_BYTES*8-1:0]  buf_flat,
    output logic [CNT_W-1:0]        cap_len
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] raw;

    always_comb begin
        base = beat_first ? '0 : cap_len;
        raw  = base + CNT_W'(beat_nbytes);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_flat <= '0;
            cap_len  <= '0;
        end else if (beat_en) begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                if (beat_first) buf_flat[8*i +: 8] <= 8'h00;
                for (int j = 0; j < BEAT_BYTES; j++) begin
                    if ((int'(base) + j == i) && (j < int'(beat_nbytes)))
                        buf_flat[8*i +: 8] <= beat_data[(BEAT_BYTES-1-j)*8 +: 8];
                end
            end
            cap_len <= (raw > CNT_W'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : raw;
        end
    end

    p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_len <= CNT_W'(BUF_BYTES));
endmodule

// File: rtl/hdrp_keysel.sv
module hdrp_keysel #(
    parameter int BUF_BYTES = 128,
    parameter int ADDR_W    = 10,
    parameter int KEY_W     = 16
) (
    input  logic [BUF_BYTES*8-1:0] buf_flat,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             kw,
    output logic [KEY_W-1:0]       key
);
    logic [7:0] b0, b1;

    always_comb begin
        b0 = 8'h00;
        b1 = 8'h00;
        for (int i = 0; i < BUF_BYTES; i++) begin
            if (ADDR_W'(i) == addr)        b0 = buf_flat[8*i +: 8];
            if (ADDR_W'(i) == addr + 1'b1) b1 = buf_flat[8*i +: 8];
        end
        unique case (kw)
            2'd1:    key = KEY_W'(b0);
            2'd2:    key = KEY_W'({b0, b1});
            default: key = '0;
        endcase
    end
endmodule

// File: rtl/hdr_parser.sv
module hdr_parser
    import hdrp_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int BUF_BYTES  = 128,
    parameter int BEAT_BYTES = 8,
    parameter int MAX_HOPS   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              in_sop,
    input  logic                              in_eop,
    input  logic [BEAT_BYTES*8-1:0]           in_data,
    input  logic [$clog2(BEAT_BYTES+1)-1:0]   in_nbytes,
    output logic                              in_ready,
    input  logic                              cfg_we,
    input  logic [$clog2(ENTRIES)-1:0]        cfg_idx,
    input  logic                              cfg_vld,
    input  logic [hdrp_pkg::STATE_W-1:0]      cfg_state,
    input  logic [hdrp_pkg::STATE_W-1:0]      cfg_state_mask,
    input  logic [hdrp_pkg::KEY_W-1:0]        cfg_key,
    input  logic [hdrp_pkg::KEY_W-1:0]        cfg_key_mask,
    input  logic [hdrp_pkg::STATE_W-1:0]      cfg_next,
    input  logic [hdrp_pkg::LEN_W-1:0]        cfg_len,
    input  logic [hdrp_pkg::LEN_W-1:0]        cfg_koff,
    input  logic [1:0]                        cfg_kw,
    input  logic                              cfg_extract,
    output logic [BUF_BYTES*8-1:0]            hdr_vec,
    output logic [(1<<hdrp_pkg::STATE_W)-1:0] hdr_found,
    output logic                              parse_done,
    output logic                              parse_err
);
    localparam int CNT_W = $clog2(BUF_BYTES + BEAT_BYTES + 1);
    localparam int POS_W = $clog2(BUF_BYTES + (1 << LEN_W)) + 1;
    localparam int HOP_W = $clog2(MAX_HOPS + 1);
    localparam int NB_W  = $clog2(BEAT_BYTES + 1);

    phase_t phase, phase_nx;

    logic               take, start, beat_en, walking;
    logic [NB_W-1:0]    beat_nb;
    logic [BUF_BYTES*8-1:0] buf_flat;
    logic [CNT_W-1:0]   cap_len;
    logic [STATE_W-1:0] cur_st;
    logic [KEY_W-1:0]   cur_key, key_nx;
    logic [POS_W-1:0]   pos, end_pos, key_addr;
    logic [HOP_W-1:0]   hops;
    logic               hit, walk_fail, walk_stop;
    rule_t              hit_rule, wr_rule;

    assign in_ready = (phase == PH_IDLE) || (phase == PH_FILL);
    assign take     = in_valid && in_ready;
    assign start    = take && in_sop && (phase == PH_IDLE);
    assign beat_en  = start || (take && (phase == PH_FILL));
    assign beat_nb  = in_eop ? in_nbytes : NB_W'(BEAT_BYTES);
    assign walking  = (phase == PH_WALK);

    assign wr_rule = '{vld: cfg_vld, st: cfg_state, st_m: cfg_state_mask,
                       key: cfg_key, key_m: cfg_key_mask, nxt: cfg_next,
                       len: cfg_len, koff: cfg_koff, kw: cfg_kw, ext: cfg_extract};

    hdrp_tcam #(.ENTRIES(ENTRIES)) u_tcam (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && (phase == PH_IDLE)), .wr_idx(cfg_idx), .wr_rule(wr_rule),
        .look_st(cur_st), .look_key(cur_key),
        .hit(hit), .hit_rule(hit_rule)
    );

    hdrp_capture #(.BUF_BYTES(BUF_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .beat_en(beat_en), .beat_first(start),
        .beat_data(in_data), .beat_nbytes(beat_nb),
        .buf_flat(buf_flat), .cap_len(cap_len)
    );

    assign end_pos  = pos + POS_W'(hit_rule.len);
    assign key_addr = pos + POS_W'(hit_rule.koff);

    hdrp_keysel #(.BUF_BYTES(BUF_BYTES), .ADDR_W(POS_W), .KEY_W(KEY_W)) u_key (
        .buf_flat(buf_flat), .addr(key_addr), .kw(hit_rule.kw), .key(key_nx)
    );

    assign walk_fail = hit && ((hops == HOP_W'(MAX_HOPS)) || (end_pos > POS_W'(cap_len)));
    assign walk_stop = !hit || walk_fail;

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: if (start)           phase_nx = in_eop ? PH_WALK : PH_FILL;
            PH_FILL: if (take && in_eop)  phase_nx = PH_WALK;
            PH_WALK: if (walk_stop)       phase_nx = PH_DONE;
            PH_DONE:                      phase_nx = PH_IDLE;
        endcase
    end

    // walk datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st     <= '0;
            cur_key    <= '0;
            pos        <= '0;
            hops       <= '0;
            hdr_vec    <= '0;
            hdr_found  <= '0;
            parse_err  <= 1'b0;
            parse_done <= 1'b0;
        end else begin
            parse_done <= walking && walk_stop;
            if (start) begin
                cur_st    <= '0;
                cur_key   <= '0;
                pos       <= '0;
                hops      <= '0;
                hdr_vec   <= '0;
                hdr_found <= '0;
                parse_err <= 1'b0;
            end else if (walking) begin
                if (walk_stop) begin
                    parse_err <= walk_fail;
                end else begin
                    cur_st             <= hit_rule.nxt;
                    cur_key            <= key_nx;
                    pos                <= end_pos;
                    hops               <= hops + 1'b1;
                    hdr_found[hit_rule.nxt] <= 1'b1;
                    for (int i = 0; i < BUF_BYTES; i++) begin
                        if (hit_rule.ext && (POS_W'(i) >= pos) && (POS_W'(i) < end_pos))
                            hdr_vec[8*i +: 8] <= buf_flat[8*i +: 8];
                    end
                end
            end
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        parse_done |=> !parse_done);
    p_err_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parse_err) |-> parse_done);
    p_found_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walking |=> ((hdr_found & $past(hdr_found)) == $past(hdr_found)));
    p_cursor_in_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        walking |-> (pos <= POS_W'(cap_len)));
    p_hop_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hops <= HOP_W'(MAX_HOPS));
    p_busy_no_table_r9: assert property (@(posedge clk) disable iff (!rst_n)
        walking |=> $stable(u_tcam.tbl[3]));
endmodule

// File: tb/hdr_parser_tb.sv
module hdr_parser_tb;
    localparam int BUF = 128;
    localparam int BB  = 8;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [BB*8-1:0] in_data = '0;
    logic [3:0] in_nbytes = '0;
    logic in_ready;
    logic cfg_we = 0, cfg_vld = 0, cfg_extract = 0;
    logic [4:0] cfg_idx = '0;
    logic [5:0] cfg_state = '0, cfg_state_mask = '0, cfg_next = '0;
    logic [15:0] cfg_key = '0, cfg_key_mask = '0;
    logic [7:0] cfg_len = '0, cfg_koff = '0;
    logic [1:0] cfg_kw = '0;
    logic [BUF*8-1:0] hdr_vec;
    logic [63:0] hdr_found;
    logic parse_done, parse_err;

    int n_chk = 0, n_bad = 0;
    logic [7:0] pkt [0:255];
    logic [BUF*8-1:0] exp_hv;
    logic [63:0] exp_found;
    logic exp_err;

    always #4 clk = ~clk;

    hdr_parser u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_nbytes(in_nbytes), .in_ready(in_ready),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vld(cfg_vld), .cfg_state(cfg_state),
        .cfg_state_mask(cfg_state_mask), .cfg_key(cfg_key), .cfg_key_mask(cfg_key_mask),
        .cfg_next(cfg_next), .cfg_len(cfg_len), .cfg_koff(cfg_koff), .cfg_kw(cfg_kw),
        .cfg_extract(cfg_extract), .hdr_vec(hdr_vec), .hdr_found(hdr_found),
        .parse_done(parse_done), .parse_err(parse_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [BUF*8-1:0] act,
                       input logic [BUF*8-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put_cfg(input int idx, input bit v, input int st, input int stm,
                           input int key, input int keym, input int nx, input int len,
                           input int koff, input int kw, input bit ext);
        cfg_idx = 5'(idx); cfg_vld = v; cfg_state = 6'(st); cfg_state_mask = 6'(stm);
        cfg_key = 16'(key); cfg_key_mask = 16'(keym); cfg_next = 6'(nx);
        cfg_len = 8'(len); cfg_koff = 8'(koff); cfg_kw = 2'(kw); cfg_extract = ext;
    endtask

    task automatic wr(input int idx, input bit v, input int st, input int stm,
                      input int key, input int keym, input int nx, input int len,
                      input int koff, input int kw, input bit ext);
        @(negedge clk);
        put_cfg(idx, v, st, stm, key, keym, nx, len, koff, kw, ext);
        cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // drive the packet; poke issues a write killing entry 3 during the second beat
    task automatic send(input int plen, input bit poke);
        for (int b = 0; b * 8 < plen; b++) begin
            @(negedge clk);
            cfg_we = 0;
            in_valid = 1;
            in_sop = (b == 0);
            in_eop = ((b + 1) * 8 >= plen);
            in_nbytes = 4'(((b + 1) * 8 >= plen) ? plen - b * 8 : 8);
            for (int j = 0; j < 8; j++)
                in_data[(7-j)*8 +: 8] = (b * 8 + j < plen) ? pkt[b*8+j] : 8'h00;
            if (poke && b == 1) begin
                put_cfg(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
                cfg_we = 1;
            end
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; cfg_we = 0;
        chk(in_ready == 1'b0, "R2 ready low while walking", BUF*8'(in_ready), '0);
        while (!parse_done) @(negedge clk);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) pkt[i] = 8'(i * 13 + seed + 1);
    endtask

    task automatic add(input int s, input int l, input int st, input bit ext);
        exp_found[st] = 1'b1;
        if (ext)
            for (int i = s; i < s + l && i < BUF; i++) exp_hv[8*i +: 8] = pkt[i];
    endtask

    task automatic compare(input string tag);
        chk(hdr_vec == exp_hv, {tag, " hdr_vec"}, hdr_vec, exp_hv);
        chk(hdr_found == exp_found, {tag, " found"}, BUF*8'(hdr_found), BUF*8'(exp_found));
        chk(parse_err == exp_err, {tag, " err"}, BUF*8'(parse_err), BUF*8'(exp_err));
    endtask

    // protocol-level model of the programmed graph
    task automatic model(input int et, input int pr, input bit rcp);
        exp_hv = '0; exp_found = '0; exp_err = 0;
        add(0, 14, 1, 1);
        if (et == 16'h0800) begin
            add(14, 20, 2, 1);
            if (pr == 6)                add(34, 20, 4, 1);
            else if (pr == 17)          add(34, 8, 5, 0);
            else if (pr == 8'hFE && rcp) begin add(34, 8, 6, 1); add(42, 20, 4, 1); end
        end else if (et == 16'h86DD) begin
            add(14, 40, 3, 1);
            if (pr == 6)       add(54, 20, 4, 1);
            else if (pr == 17) add(54, 8, 5, 0);
        end else if (et == 16'h8801) add(14, 6, 10, 1);
        else if (et == 16'h8850)     add(14, 4, 9, 1);
    endtask

    task automatic build(input int et, input int pr, input int seed);
        fill(seed);
        pkt[12] = 8'(et >> 8); pkt[13] = 8'(et);
        pkt[23] = 8'(pr); pkt[20] = 8'(pr); pkt[34] = 8'd6;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ets[5];
        int prs[4];
        logic [BUF*8-1:0] hold_hv;
        ets = '{16'h0800, 16'h86DD, 16'h1234, 16'h8801, 16'h8850};
        prs = '{6, 17, 8'hFE, 8'h33};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1 && parse_done == 0 && parse_err == 0 && hdr_found == 0 && hdr_vec == 0,
            "R1 reset outputs", BUF*8'(hdr_found), '0);

        // R1: empty table -> root misses
        build(16'h0800, 6, 0);
        send(60, 0);
        exp_hv = '0; exp_found = '0; exp_err = 0;
        compare("R1 empty table");

        // default graph
        wr(0, 1, 0, 6'h3F, 0, 0, 1, 14, 12, 2, 1);
        wr(1, 1, 1, 6'h3F, 16'h0800, 16'hFFFF, 2, 20, 9, 1, 1);
        wr(2, 1, 1, 6'h3F, 16'h86DD, 16'hFFFF, 3, 40, 6, 1, 1);
        wr(3, 1, 2, 6'h3F, 6, 16'hFFFF, 4, 20, 0, 0, 1);
        wr(4, 1, 2, 6'h3F, 17, 16'hFFFF, 5, 8, 0, 0, 0);
        wr(5, 1, 3, 6'h3F, 6, 16'hFFFF, 4, 20, 0, 0, 1);
        wr(6, 1, 3, 6'h3F, 17, 16'hFFFF, 5, 8, 0, 0, 0);
        wr(10, 1, 1, 6'h3F, 16'h8801, 16'hFFFF, 10, 6, 0, 0, 1);
        wr(11, 1, 1, 6'h3F, 16'h8800, 16'hFF00, 9, 4, 0, 0, 1);
        wr(12, 1, 1, 6'h3F, 16'h9999, 16'hFFFF, 8, 1, 0, 0, 0);
        wr(13, 1, 8, 6'h3F, 0, 0, 8, 1, 0, 0, 0);

        // sweep: R3 priority/mask, R4 walk, R5 extract, R6 no-match accept
        for (int e = 0; e < 5; e++)
            for (int p = 0; p < 4; p++) begin
                build(ets[e], prs[p], e * 4 + p);
                send(100, 0);
                model(ets[e], prs[p], 0);
                compare("R3 R4 R5 R6 sweep");
            end

        // R10: outputs hold after the pulse
        hold_hv = hdr_vec;
        @(negedge clk);
        chk(parse_done == 0, "R10 done one cycle", BUF*8'(parse_done), '0);
        repeat (3) @(negedge clk);
        chk(hdr_vec == hold_hv && hdr_found == exp_found, "R10 hold", hdr_vec, hold_hv);

        // R7: truncation inside IPv4, exact-end TCP, one byte short TCP
        build(16'h0800, 6, 40); send(30, 0);
        model(16'h0800, 0, 0); exp_hv = '0; exp_found = '0; add(0, 14, 1, 1); exp_err = 1;
        compare("R7 cut in ipv4");
        build(16'h0800, 6, 41); send(54, 0); model(16'h0800, 6, 0); exp_err = 0;
        compare("R7 exact end");
        build(16'h0800, 6, 42); send(53, 0);
        model(16'h0800, 0, 0); exp_err = 1;
        compare("R7 one short");

        // R2: long packet, bytes beyond buffer dropped, lane order
        build(16'h86DD, 6, 43); send(150, 0); model(16'h86DD, 6, 0);
        compare("R2 long packet");

        // R8: self loop until hop limit
        build(16'h9999, 0, 44); send(64, 0);
        exp_hv = '0; exp_found = '0; add(0, 14, 1, 1); exp_found[8] = 1; exp_err = 1;
        compare("R8 hop limit");

        // R9: write attempted mid-packet is ignored; entry 3 still routes TCP
        build(16'h0800, 17, 45); send(80, 1); model(16'h0800, 17, 0);
        compare("R9 poke packet");
        build(16'h0800, 6, 46); send(80, 0); model(16'h0800, 6, 0);
        compare("R9 entry kept");

        // R11: add custom header between IPv4 and TCP, sweep again
        wr(7, 1, 2, 6'h3F, 8'hFE, 16'hFFFF, 6, 8, 0, 1, 1);
        wr(8, 1, 6, 6'h3F, 6, 16'hFFFF, 4, 20, 0, 0, 1);
        for (int e = 0; e < 5; e++)
            for (int p = 0; p < 4; p++) begin
                build(ets[e], prs[p], 50 + e * 4 + p);
                send(100, 0);
                model(ets[e], prs[p], 1);
                compare("R11 reconfigured sweep");
            end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule